// File: doc/BRIEF.md
# Priority-Ordered Up/Down Loadable Counter

This block is a synchronous binary counter. On each rising clock edge its register takes one of four next values, and a fixed ranking of the control inputs decides which one. The four choices are a parallel value, zero, its own current value, or its current value stepped by one in the chosen direction. Every one of the sixteen settings of the four control inputs leads to exactly one of these choices. No combination leaves the next value undefined.

From strongest to weakest, the ranking is: parallel load, then clear, then hold when disabled, then count. Load and clear act whether or not the count enable is high. A design that needs a different ranking only has to reorder the ranking in the control module. The datapath does not change.

Top module: `prio_counter`

## Requirements
- R1: With load, clear low and enable high, a high direction input makes the count rise by one on the next rising edge.
- R2: With load, clear low and enable high, a low direction input makes the count fall by one on the next rising edge.
- R3: Counting up from the all-ones value gives zero.
- R4: Counting down from zero gives the all-ones value.
- R5: With load and clear low and enable low, the count keeps its value, whatever the direction input is.
- R6: With load low and clear high, the count becomes zero on the next edge, whatever enable and direction are.
- R7: With load high, the count takes the parallel value on the next edge, even when clear is also high and whatever enable and direction are.
- R8: The count changes only at a rising clock edge. Input changes between edges do not reach the output until the next edge.
- R9: The count width is a parameter with a default of 8 bits. The parallel value has the same width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| countUp | input | 1 | Direction: 1 counts up, 0 counts down |
| countEn | input | 1 | Count enable; low holds the count |
| clearReq | input | 1 | Synchronous clear to zero |
| loadReq | input | 1 | Synchronous parallel load, highest rank |
| loadValue | input | WIDTH | Value taken on a load |
| count | output | WIDTH | Current count |

## Verification
All results are due exactly one rising edge after the controls that cause them. There is one register between inputs and output, and there is no reset, so the first known value comes from a clear or load.

The bench drives the controls shortly after the falling edge. It advances its behavioural model at the rising edge and compares the output one nanosecond later, before the next falling edge. To cover R8, it also changes the controls halfway through a cycle and confirms that the output stays put until the following edge.

// File: rtl/prio_counter_pkg.sv
package prio_counter_pkg;

  // One-hot selection of the next-value source, plus the step direction.
  typedef struct packed {
    logic takeLoad;
    logic takeZero;
    logic keepValue;
    logic takeStep;
    logic stepUp;
  } cntStrobes_t;

endpackage

// File: rtl/prio_counter_ctrl.sv
module prio_counter_ctrl
  import prio_counter_pkg::*;
(
  input  logic        countUp,
  input  logic        countEn,
  input  logic        clearReq,
  input  logic        loadReq,
  output cntStrobes_t strobes
);

  // Ordered overrides: each later statement ranks above the earlier ones.
  always_comb begin
    strobes          = '0;
    strobes.stepUp   = countUp;
    strobes.takeStep = 1'b1;
    if (!countEn) begin
      strobes.takeStep  = 1'b0;
      strobes.keepValue = 1'b1;
    end
    if (clearReq) begin
      strobes.takeStep  = 1'b0;
      strobes.keepValue = 1'b0;
      strobes.takeZero  = 1'b1;
    end
    if (loadReq) begin
      strobes.takeStep  = 1'b0;
      strobes.keepValue = 1'b0;
      strobes.takeZero  = 1'b0;
      strobes.takeLoad  = 1'b1;
    end
  end

  // Exactly one source is chosen for every input combination (R5, R6, R7).
  always_comb begin
    a_one_source_r7 : assert ($countones({strobes.takeLoad, strobes.takeZero,
                                          strobes.keepValue, strobes.takeStep}) == 1)
      else $error("control selected no source or several sources");
  end

endmodule

// File: rtl/prio_counter_dp.sv
module prio_counter_dp
  import prio_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  cntStrobes_t      strobes,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] nextCount;
  logic             pastValid = 1'b0;

  // Modulo arithmetic gives the wrap in both directions.
  assign stepped = strobes.stepUp ? countReg + ONE : countReg - ONE;

  always_comb begin
    nextCount = countReg;
    if (strobes.takeStep)  nextCount = stepped;
    if (strobes.keepValue) nextCount = countReg;
    if (strobes.takeZero)  nextCount = ZERO;
    if (strobes.takeLoad)  nextCount = loadValue;
  end

  always_ff @(posedge clk) begin
    countReg  <= nextCount;
    pastValid <= 1'b1;
  end

  assign count = countReg;

  p_keep_r5 : assert property (@(posedge clk) disable iff (!pastValid)
    strobes.keepValue |=> countReg == $past(countReg))
    else $error("hold strobe did not keep the count");

  p_zero_r6 : assert property (@(posedge clk) disable iff (!pastValid)
    strobes.takeZero |=> countReg == ZERO)
    else $error("zero strobe did not clear the count");

endmodule

// File: rtl/prio_counter.sv
module prio_counter
  import prio_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             countUp,
  input  logic             countEn,
  input  logic             clearReq,
  input  logic             loadReq,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  cntStrobes_t strobes;
  logic        pastValid = 1'b0;

  prio_counter_ctrl i_ctrl (
    .countUp  (countUp),
    .countEn  (countEn),
    .clearReq (clearReq),
    .loadReq  (loadReq),
    .strobes  (strobes)
  );

  prio_counter_dp #(.WIDTH(WIDTH)) i_dp (
    .clk       (clk),
    .strobes   (strobes),
    .loadValue (loadValue),
    .count     (count)
  );

  always_ff @(posedge clk) pastValid <= 1'b1;

  p_load_wins_r7 : assert property (@(posedge clk) disable iff (!pastValid)
    loadReq |=> count == $past(loadValue))
    else $error("load did not take the parallel value");

  p_clear_r6 : assert property (@(posedge clk) disable iff (!pastValid)
    (!loadReq && clearReq) |=> count == '0)
    else $error("clear did not zero the count");

  p_hold_r5 : assert property (@(posedge clk) disable iff (!pastValid)
    (!loadReq && !clearReq && !countEn) |=> $stable(count))
    else $error("disabled counter moved");

  p_up_r1 : assert property (@(posedge clk) disable iff (!pastValid)
    (!loadReq && !clearReq && countEn && countUp) |=> count == WIDTH'($past(count) + 1'b1))
    else $error("up step wrong");

  p_down_r2 : assert property (@(posedge clk) disable iff (!pastValid)
    (!loadReq && !clearReq && countEn && !countUp) |=> count == WIDTH'($past(count) - 1'b1))
    else $error("down step wrong");

  p_wrap_up_r3 : assert property (@(posedge clk) disable iff (!pastValid)
    (!loadReq && !clearReq && countEn && countUp && count == ALL_ONES) |=> count == '0)
    else $error("up wrap wrong");

  p_wrap_down_r4 : assert property (@(posedge clk) disable iff (!pastValid)
    (!loadReq && !clearReq && countEn && !countUp && count == '0) |=> count == ALL_ONES)
    else $error("down wrap wrong");

endmodule

// File: tb/test_prio_counter.sv
`timescale 1ns/1ps
module test_prio_counter;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         countUp = 1'b0, countEn = 1'b0, clearReq = 1'b0, loadReq = 1'b0;
  logic [W-1:0] loadValue = '0;
  logic [W-1:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int expCount = 0;

  always #2.5 clk = ~clk;

  prio_counter #(.WIDTH(W)) i_prio_counter (
    .clk(clk), .countUp(countUp), .countEn(countEn),
    .clearReq(clearReq), .loadReq(loadReq),
    .loadValue(loadValue), .count(count)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: count=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply one cycle of controls and compare against the behavioural model.
  task automatic step(input bit up, input bit en, input bit clr, input bit ld,
                      input int val);
    string tag;
    @(negedge clk);
    countUp = up; countEn = en; clearReq = clr; loadReq = ld;
    loadValue = W'(val);
    if (ld)       begin expCount = val % 256;                  tag = "R7 load"; end
    else if (clr) begin expCount = 0;                          tag = "R6 clear"; end
    else if (!en) begin                                        tag = "R5 hold"; end
    else if (up)  begin tag = (expCount == 255) ? "R3 wrap up" : "R1 up";
                        expCount = (expCount + 1) % 256; end
    else          begin tag = (expCount == 0) ? "R4 wrap down" : "R2 down";
                        expCount = (expCount + 255) % 256; end
    @(posedge clk); #1;
    check(tag, int'(count), expCount);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Width and power-up clear (R9, R6)
    check("R9 width", $bits(count), 8);
    step(1, 1, 1, 0, 8'h5A);
    // Load beats clear (R7)
    step(0, 0, 1, 1, 8'hC3);
    // Wrap up and down (R3, R4)
    step(0, 0, 0, 1, 8'hFF);
    step(1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    // Runs up and down (R1, R2)
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, i);
    for (int i = 0; i < 30; i++) step(0, 1, 0, 0, i);
    // All sixteen control settings, from several starting counts
    for (int rep = 0; rep < 6; rep++) begin
      for (int c = 0; c < 16; c++) begin
        step(0, 0, 0, 1, rep * 51);
        step(c[0], c[1], c[2], c[3], (rep * 37 + c * 13) % 256);
        step(c[3], c[2], c[1], c[0], (rep * 91 + c * 7) % 256);
      end
    end
    // Mid-cycle input changes stay invisible until the next edge (R8)
    step(0, 0, 0, 1, 8'h40);
    @(negedge clk);
    loadValue = 8'h99; loadReq = 1'b1; clearReq = 1'b1; countEn = 1'b1;
    #1 check("R8 no change between edges", int'(count), 8'h40);
    @(posedge clk); #1;
    check("R8 change at edge", int'(count), 8'h99);
    expCount = 8'h99;
    step(1, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule